// File: doc/BRIEF.md
# Cache Way Allocation Selector

This block decides which of the four ways in one set of a set-associative cache takes a new line during a fill. It sees the four valid bits of the addressed set and an allocate strobe. A mode input switches between unrestricted allocation and a half-lock mode. In half-lock mode ways 0 and 1 are kept out of allocation, so their contents stay frozen. The block returns the chosen way both as a one-hot vector and as a 2-bit index, together with a ready flag. All three are combinational in the cycle of the strobe.

An invalid way is always preferred to replacing a valid one. When every eligible way is valid, the victim comes from a 2-bit round-robin counter held inside the block. The counter moves only on such replacements. In normal mode it counts modulo 4. In half-lock mode only its high bit toggles, so ways 2 and 3 alternate. Software may change the mode between any two allocations. The counter keeps its value across a mode change.

Top module: `way_alloc_sel`

## Requirements
- R1: In normal mode (`half_lock`=0) with at least one invalid way, the selected way is the lowest-numbered way whose `set_valid` bit is 0.
- R2: In normal mode with all four valid bits set, the selected way equals the counter value, and the counter then advances by one, wrapping from 3 to 0.
- R3: In half-lock mode (`half_lock`=1), if way 2 or way 3 is invalid, the lower-numbered invalid one of those two is selected, whatever the valid bits of ways 0 and 1 are.
- R4: In half-lock mode with ways 2 and 3 both valid, way 2 is selected when counter bit 1 is 0 and way 3 when it is 1.
- R5: In half-lock mode no allocation ever selects way 0 or way 1. A half-lock replacement (R4) inverts counter bit 1 and leaves counter bit 0 unchanged.
- R6: An allocation that fills an invalid way (R1 or R3) leaves the counter unchanged in both modes.
- R7: Changing `half_lock` between allocations neither resets nor alters the counter. Each allocation uses the mode present in its own cycle.
- R8: While `rst_n` is 0, `ready` and `victim_onehot` are 0 and the counter is cleared to 0.
- R9: The result appears in the same cycle as `alloc_req`. `ready` equals `alloc_req` outside reset. When ready, `victim_onehot` has exactly the bit `victim_idx` set (bit n = way n). When `alloc_req` is 0, the outputs are 0 and the counter holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Allocate strobe for the current set |
| half_lock | input | 1 | 1 = allocate only into ways 2 and 3 |
| set_valid | input | 4 | Valid bits of the addressed set, bit n = way n |
| victim_onehot | output | 4 | Selected way, one-hot; 0 when idle |
| victim_idx | output | 2 | Selected way as a binary index; 0 when idle |
| ready | output | 1 | The selection outputs hold a result this cycle |

## Verification
The victim outputs and `ready` settle in the same cycle that `alloc_req` is driven. The counter changes only at the next rising edge, so a replacement shows its effect on the next allocation and not on its own. The bench drives each request on the falling edge. Its monitor reads the outputs 2 ns later, in the same low phase, and compares them with a queued prediction. The bench's model of the counter is advanced when each prediction is pushed, so the next request is predicted from the post-edge counter value. Idle cycles, mode changes and resets are placed between requests, and their effect on the counter is checked through the victim of the next replacement.

// File: rtl/way_alloc_pkg.sv
package way_alloc_pkg;
  localparam int WAYS  = 4;
  localparam int IDX_W = $clog2(WAYS);
  localparam int HALF  = WAYS / 2;

  typedef logic [WAYS-1:0]  way_vec_t;
  typedef logic [IDX_W-1:0] way_idx_t;

  // Binary way index to one-hot vector.
  function automatic way_vec_t idx_to_onehot(way_idx_t i);
    return way_vec_t'(1) << i;
  endfunction

  // Next counter value after a replacement among valid ways.
  function automatic way_idx_t rr_step(way_idx_t c, logic half);
    way_idx_t n;
    if (half) begin
      n = c;
      n[IDX_W-1] = ~c[IDX_W-1];
    end else begin
      n = c + way_idx_t'(1);
    end
    return n;
  endfunction

  // Victim in half-lock mode when the upper ways are all valid.
  function automatic way_idx_t locked_pick(way_idx_t c);
    return way_idx_t'(HALF) + way_idx_t'(c[IDX_W-1]);
  endfunction
endpackage

// File: rtl/way_alloc_scan.sv
module way_alloc_scan
  import way_alloc_pkg::*;
#(
  parameter int N = WAYS
) (
  input  logic [N-1:0]         valid,
  input  logic [N-1:0]         elig,
  output logic                 found,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  logic [N:0]   seen;
  logic [N-1:0] hit;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign hit[g]    = ~valid[g] & elig[g] & ~seen[g];
    assign seen[g+1] = seen[g] | (~valid[g] & elig[g]);
  end

  assign found = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/way_alloc_rr.sv
module way_alloc_rr
  import way_alloc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step_en,
  input  logic     half,
  output way_idx_t cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (step_en) cnt_q <= rr_step(cnt_q, half);
  end
endmodule

// File: rtl/way_alloc_sel.sv
module way_alloc_sel
  import way_alloc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alloc_req,
  input  logic       half_lock,
  input  logic [3:0] set_valid,
  output logic [3:0] victim_onehot,
  output logic [1:0] victim_idx,
  output logic       ready
);
  way_vec_t elig;
  logic     inv_found;
  way_idx_t inv_idx;
  way_idx_t cnt_q;
  way_idx_t pick;
  logic     repl_evt;

  // Eligible ways: all in normal mode, upper half in half-lock mode.
  for (genvar g = 0; g < WAYS; g++) begin : g_elig
    if (g >= HALF) begin : g_upper
      assign elig[g] = 1'b1;
    end else begin : g_lower
      assign elig[g] = ~half_lock;
    end
  end

  way_alloc_scan #(.N(WAYS)) scan_i (
    .valid (set_valid),
    .elig  (elig),
    .found (inv_found),
    .idx   (inv_idx)
  );

  assign ready    = alloc_req & rst_n;
  assign repl_evt = ready & ~inv_found;

  way_alloc_rr rr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (repl_evt),
    .half    (half_lock),
    .cnt_q   (cnt_q)
  );

  always_comb begin
    if (inv_found)      pick = inv_idx;
    else if (half_lock) pick = locked_pick(cnt_q);
    else                pick = cnt_q;
  end

  assign victim_idx    = ready ? pick : '0;
  assign victim_onehot = ready ? idx_to_onehot(pick) : '0;
endmodule

// File: rtl/way_alloc_sel_chk.sv
module way_alloc_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       alloc_req,
  input logic       half_lock,
  input logic [3:0] set_valid,
  input logic [3:0] victim_onehot,
  input logic [1:0] victim_idx,
  input logic       ready,
  input logic [1:0] cnt_q
);
  a_r1_way0_first: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && !half_lock && !set_valid[0] |-> victim_idx == 2'd0);

  a_r1_way1_next: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && !half_lock && set_valid[1:0] == 2'b01 |-> victim_idx == 2'd1);

  a_r2_rr_victim: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && !half_lock && &set_valid |-> victim_idx == cnt_q);

  a_r2_rr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && !half_lock && &set_valid |=> cnt_q == $past(cnt_q) + 2'd1);

  a_r3_upper_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && half_lock && !set_valid[2] |-> victim_idx == 2'd2);

  a_r4_locked_rr: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && half_lock && &set_valid[3:2] |-> victim_idx == {1'b1, cnt_q[1]});

  a_r5_lower_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && half_lock |-> victim_onehot[1:0] == 2'b00);

  a_r5_high_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && half_lock && &set_valid[3:2] |=>
      cnt_q[1] != $past(cnt_q[1]) && cnt_q[0] == $past(cnt_q[0]));

  a_r6_fill_holds_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && ((!half_lock && !(&set_valid)) || (half_lock && !(&set_valid[3:2])))
      |=> $stable(cnt_q));

  a_r8_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> !ready && victim_onehot == 4'd0);

  a_r9_onehot_match: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> $countones(victim_onehot) == 1 && victim_onehot[victim_idx]);

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_req |-> !ready && victim_onehot == 4'd0 ##1 $stable(cnt_q));
endmodule

bind way_alloc_sel way_alloc_sel_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .alloc_req     (alloc_req),
  .half_lock     (half_lock),
  .set_valid     (set_valid),
  .victim_onehot (victim_onehot),
  .victim_idx    (victim_idx),
  .ready         (ready),
  .cnt_q         (cnt_q)
);

// File: tb/way_alloc_sel_tb_top.sv
module way_alloc_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_req = 1'b0;
  logic       half_lock = 1'b0;
  logic [3:0] set_valid = 4'd0;
  logic [3:0] victim_onehot;
  logic [1:0] victim_idx;
  logic       ready;

  always #4 clk = ~clk;

  way_alloc_sel dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_req     (alloc_req),
    .half_lock     (half_lock),
    .set_valid     (set_valid),
    .victim_onehot (victim_onehot),
    .victim_idx    (victim_idx),
    .ready         (ready)
  );

  typedef struct {
    logic [1:0] way;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  logic [1:0] model_cnt = 2'd0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: apply one allocation on the falling edge and queue its prediction.
  task automatic alloc(input bit half, input logic [3:0] v, input string tag);
    exp_t e;
    bit   hit;
    @(negedge clk);
    half_lock = half;
    set_valid = v;
    alloc_req = 1'b1;
    hit = 1'b0;
    e.tag = tag;
    e.way = 2'd0;
    for (int w = (half ? 2 : 0); w < 4; w++) begin
      if (!hit && !v[w]) begin
        hit = 1'b1;
        e.way = 2'(w);
      end
    end
    if (!hit) begin
      if (half) begin
        e.way = model_cnt[1] ? 2'd3 : 2'd2;
        model_cnt[1] = ~model_cnt[1];
      end else begin
        e.way = model_cnt;
        model_cnt = model_cnt + 2'd1;
      end
    end
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      alloc_req = 1'b0;
      set_valid = 4'hF;
      #2;
      check(ready == 1'b0 && victim_onehot == 4'd0, "R9 idle outputs",
            int'({ready, victim_onehot}), 0);
    end
  endtask

  // Monitor: compare each ready result against the queue head.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected ready", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(victim_idx == e.way, e.tag, int'(victim_idx), int'(e.way));
          check(victim_onehot == (4'd1 << e.way), {e.tag, " onehot"},
                int'(victim_onehot), int'(4'd1 << e.way));
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        check(1'b0, "watchdog", cyc, 5000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    // R8: reset keeps outputs quiet even with a request present.
    alloc_req = 1'b1;
    set_valid = 4'hF;
    repeat (2) @(negedge clk);
    #2;
    check(ready == 1'b0 && victim_onehot == 4'd0, "R8 reset outputs",
          int'({ready, victim_onehot}), 0);
    alloc_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // R1: lowest invalid way in normal mode.
    alloc(1'b0, 4'b0000, "R1 all invalid");
    alloc(1'b0, 4'b0001, "R1 way1");
    alloc(1'b0, 4'b1011, "R1 way2");
    alloc(1'b0, 4'b0111, "R1 way3");
    // R2: round robin with wrap.
    for (int i = 0; i < 5; i++) alloc(1'b0, 4'hF, "R2 round robin");
    // R6: fill into invalid way holds counter (now 1).
    alloc(1'b0, 4'b0101, "R6 fill normal");
    alloc(1'b0, 4'hF, "R6 counter held");
    // R4/R5: half-lock replacements (counter 2 -> way3, high bit toggles).
    alloc(1'b1, 4'hF, "R4 locked way3");
    alloc(1'b1, 4'hF, "R4 locked way2");
    alloc(1'b1, 4'hF, "R5 alternate");
    // R3: invalid upper ways, lower-way validity ignored.
    alloc(1'b1, 4'b0011, "R3 both invalid");
    alloc(1'b1, 4'b1000, "R3 way2 invalid");
    alloc(1'b1, 4'b0100, "R3 way3 invalid");
    alloc(1'b1, 4'b0111, "R3 lower ignored");
    alloc(1'b1, 4'hF, "R6 fill half held");
    // R7: mode switches keep the counter.
    alloc(1'b0, 4'hF, "R7 to normal");
    alloc(1'b1, 4'hF, "R7 to half");
    alloc(1'b0, 4'hF, "R7 back normal");
    // R9: idle cycles do not move the counter.
    idle(3);
    alloc(1'b0, 4'hF, "R9 after idle");
    alloc(1'b1, 4'hF, "R5 low bit kept");
    idle(1);
    // R8: mid-run reset clears the counter.
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check(ready == 1'b0, "R8 reset mid-run", int'(ready), 0);
    @(negedge clk);
    rst_n = 1'b1;
    model_cnt = 2'd0;
    alloc(1'b0, 4'hF, "R8 counter cleared");
    alloc(1'b1, 4'hF, "R8 half after reset");
    idle(2);
    check(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule